// File: doc/BRIEF.md
# I2C Bit-Level Master with Bus Recovery

This block is the bit engine of an I2C master. A controller hands it one byte-level command at a time: bus recovery, start condition, stop condition, byte write, or byte read with a chosen acknowledge level. The engine turns each command into a fixed pattern of SCL and SDA levels. Every level is held for a whole number of timing units. A unit lasts a programmable number of system clocks and stands for one quarter of the SCL period.

Both bus pins are open-drain. Each output either pulls its line low or lets it float, and an external pull-up supplies the high level. The engine reads the SDA line back to capture received data bits and the slave's acknowledge. When a command finishes, the engine gives a single done pulse. It also updates the received byte after a read, or the sampled acknowledge after a write. The engine does not handle clock stretching, arbitration between masters, or slave operation.

Commands arrive over a valid/ready handshake. The engine raises `cmd_ready` only while it is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. If the controller holds `cmd_valid` high while the engine is busy, the command simply waits, and nothing is lost or dropped. There is no back-pressure on the result: `done` is a one-cycle pulse, and the response outputs keep their value until the next command of the same kind completes.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, neither bus line is pulled, `cmd_ready` is 1 and `done` is 0.
- R2: A command is accepted only on an edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from the cycle after acceptance until the completion cycle. Each command gives exactly one `done` pulse. That pulse, together with `cmd_ready` high again, appears in the cycle after the edge that ends the last unit.
- R3: One unit lasts N system clocks, where N is `quarter_div`, or 1 when `quarter_div` is 0. The value is captured at acceptance, so later changes do not affect the running command.
- R4: Start (`cmd_op`=1) takes 3 units. Unit 0 releases SDA and leaves SCL as it was. Unit 1 releases both lines. Unit 2 pulls SDA low while SCL stays released.
- R5: Stop (`cmd_op`=2) takes 4 units. Unit 0 pulls SCL low and leaves SDA as it was. Unit 1 pulls both lines low. Unit 2 releases SCL with SDA still low. Unit 3 releases both lines.
- R6: Write (`cmd_op`=3) sends `cmd_data` most significant bit first, 4 units per bit. Unit 0 pulls SCL low and leaves SDA unchanged. Unit 1 pulls SCL low and puts the bit on SDA, where 0 pulls the line and 1 releases it. Units 2 and 3 release SCL. SDA never changes while SCL is released.
- R7: A ninth write clock follows and takes 5 units. SCL is low for units 0 and 1, released for units 2 and 3, and low for unit 4. SDA is released from unit 1 onward. At completion, `rsp_nack` equals the SDA line level sampled at the end of unit 3: 0 means acknowledge, 1 means not acknowledge. A write lasts 37 units in total.
- R8: Read (`cmd_op`=4) releases SDA and clocks 8 bits, 3 units each: SCL low for one unit, then released for two. The line is sampled at the end of the first released unit. Bits are assembled most significant first into `rsp_data`.
- R9: The read acknowledge clock takes 5 units, with the same SCL pattern as R7. From unit 1 onward SDA is pulled low when `cmd_nack`=0 and released when it is 1. A read lasts 29 units in total.
- R10: Recovery (`cmd_op`=0) first releases both lines for 1 unit. It then gives 9 SCL pulses, each low for 2 units and released for 2 units, with SDA released throughout. It ends with the 4-unit stop of R5. The whole sequence lasts 41 units.
- R11: Opcodes 5, 6 and 7 perform no bus activity. They produce `done` in the cycle after acceptance.
- R12: `rsp_data` changes only when a read completes, and `rsp_nack` changes only when a write completes.
- R13: While the engine is idle, both line outputs keep the levels left by the last command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quarter_div | input | DIV_W | System clocks per timing unit, where 0 counts as 1 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 3 | 0 recover, 1 start, 2 stop, 3 write, 4 read |
| cmd_data | input | BYTE_W | Byte to transmit on a write |
| cmd_nack | input | 1 | Read acknowledge level: 0 acknowledge, 1 not acknowledge |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | BYTE_W | Byte received by the last read |
| rsp_nack | output | 1 | Acknowledge sampled by the last write |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The line outputs are registered, and they take the levels for unit k at the edge that is k·N clocks after the accepting edge. The bench therefore checks each unit in the first cycle after that edge, at the falling clock edge. `done`, `cmd_ready` and the response outputs are due one cycle after the edge that closes the last unit, which is U·N clocks after acceptance for a U-unit command. The bench waits exactly that long before comparing, and it checks again one cycle later that the pulse has gone and that the lines are still held. The slave model changes its SDA pull only at the start of a unit, so the line is steady at every edge where the engine samples it.

// File: rtl/i2c_be_pkg.sv
package i2c_be_pkg;

  // Opcodes seen on cmd_op
  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  // Sequencer states
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RREL = 3'd1,
    S_RCLK = 3'd2,
    S_STA  = 3'd3,
    S_STP  = 3'd4,
    S_WR   = 3'd5,
    S_RD   = 3'd6
  } seq_e;

endpackage

// File: rtl/i2c_be_tick.sv
// Unit timer: restarted by each accepted command, and the divisor is captured at that moment
module i2c_be_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
      lim_q <= (div_in == '0) ? '0 : div_in - 1'b1;
    end else if (cnt_q == lim_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == lim_q);
endmodule

// File: rtl/i2c_be_shift.sv
// Byte shifter shared by transmit (msb out) and receive (lsb in)
module i2c_be_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         msb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end

  assign msb = q[W-1];
endmodule

// File: rtl/i2c_be_seq.sv
// Phase sequencer: state, phase within a bit, bit index, and registered line levels
module i2c_be_seq
  import i2c_be_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int RCV_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] op,
  input  logic       nack_in,
  input  logic       tick,
  input  logic       tx_msb,
  input  logic       sda_in,
  output logic       idle,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       sh_en,
  output logic       fin,
  output logic       fin_rd,
  output logic       fin_wr,
  output logic       ack_smp,
  output seq_e       st_o
);
  localparam int MAXB = (RCV_PULSES > BYTE_W) ? RCV_PULSES : BYTE_W;
  localparam int CW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] ACK_IDX  = CW'(BYTE_W);
  localparam logic [CW-1:0] RCV_LAST = CW'(RCV_PULSES - 1);

  seq_e          st_q, n_st;
  logic [2:0]    ph_q, n_ph;
  logic [CW-1:0] bt_q, n_bt;
  logic          scl_q, sda_q, n_scl, n_sda;
  logic          nack_q, ack_q, step, at_ack;

  // Index of the last unit in the current bit slot
  function automatic logic [2:0] last_ph(seq_e s, logic ack_slot);
    case (s)
      S_RCLK, S_STP: last_ph = 3'd3;
      S_STA:         last_ph = 3'd2;
      S_WR:          last_ph = ack_slot ? 3'd4 : 3'd3;
      S_RD:          last_ph = ack_slot ? 3'd4 : 3'd2;
      default:       last_ph = 3'd0;
    endcase
  endfunction

  assign at_ack = (bt_q == ACK_IDX);

  always_comb begin
    n_st = st_q;
    n_ph = ph_q;
    n_bt = bt_q;
    fin  = 1'b0;
    if (st_q == S_IDLE) begin
      if (accept) begin
        n_ph = '0;
        n_bt = '0;
        case (op_e'(op))
          OP_RECOVER: n_st = S_RREL;
          OP_START:   n_st = S_STA;
          OP_STOP:    n_st = S_STP;
          OP_WRITE:   n_st = S_WR;
          OP_READ:    n_st = S_RD;
          default:    fin  = 1'b1;
        endcase
      end
    end else if (tick) begin
      if (ph_q != last_ph(st_q, at_ack)) begin
        n_ph = ph_q + 3'd1;
      end else begin
        n_ph = '0;
        case (st_q)
          S_RREL: begin
            n_st = S_RCLK;
            n_bt = '0;
          end
          S_RCLK: begin
            if (bt_q == RCV_LAST) begin
              n_st = S_STP;
              n_bt = '0;
            end else begin
              n_bt = bt_q + 1'b1;
            end
          end
          S_WR, S_RD: begin
            if (at_ack) begin
              n_st = S_IDLE;
              fin  = 1'b1;
            end else begin
              n_bt = bt_q + 1'b1;
            end
          end
          default: begin
            n_st = S_IDLE;
            fin  = 1'b1;
          end
        endcase
      end
    end
  end

  assign step = accept || (tick && (st_q != S_IDLE));

  // Line levels for the unit being entered (1 = pull low); unlisted lines keep their level
  always_comb begin
    n_scl = scl_q;
    n_sda = sda_q;
    if (step && (n_st != S_IDLE)) begin
      case (n_st)
        S_RREL: begin
          n_scl = 1'b0;
          n_sda = 1'b0;
        end
        S_RCLK: begin
          n_sda = 1'b0;
          n_scl = (n_ph < 3'd2);
        end
        S_STA: begin
          case (n_ph)
            3'd0:    n_sda = 1'b0;
            3'd1:    begin n_scl = 1'b0; n_sda = 1'b0; end
            default: begin n_scl = 1'b0; n_sda = 1'b1; end
          endcase
        end
        S_STP: begin
          case (n_ph)
            3'd0:    n_scl = 1'b1;
            3'd1:    begin n_scl = 1'b1; n_sda = 1'b1; end
            3'd2:    begin n_scl = 1'b0; n_sda = 1'b1; end
            default: begin n_scl = 1'b0; n_sda = 1'b0; end
          endcase
        end
        S_WR: begin
          n_scl = (n_ph < 3'd2) || (n_ph == 3'd4);
          if (n_ph == 3'd1) n_sda = (n_bt == ACK_IDX) ? 1'b0 : !tx_msb;
        end
        S_RD: begin
          if (n_bt == ACK_IDX) begin
            n_scl = (n_ph < 3'd2) || (n_ph == 3'd4);
            if (n_ph == 3'd1) n_sda = !nack_q;
          end else begin
            n_sda = 1'b0;
            n_scl = (n_ph == 3'd0);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ph_q   <= '0;
      bt_q   <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      nack_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q  <= n_st;
      ph_q  <= n_ph;
      bt_q  <= n_bt;
      scl_q <= n_scl;
      sda_q <= n_sda;
      if (accept) nack_q <= nack_in;
      if (tick && (st_q == S_WR) && at_ack && (ph_q == 3'd3)) ack_q <= sda_in;
    end
  end

  // Shift at the end of a transmitted data bit, or at the sample point of a received bit
  assign sh_en = tick && !at_ack &&
                 (((st_q == S_WR) && (ph_q == last_ph(S_WR, 1'b0))) ||
                  ((st_q == S_RD) && (ph_q == 3'd1)));

  assign idle     = (st_q == S_IDLE);
  assign scl_pull = scl_q;
  assign sda_pull = sda_q;
  assign fin_rd   = fin && (st_q == S_RD);
  assign fin_wr   = fin && (st_q == S_WR);
  assign ack_smp  = ack_q;
  assign st_o     = st_q;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_be_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int RCV_PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  quarter_div,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_nack,
  output logic              done,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_nack,
  output logic              scl_pull,
  output logic              sda_pull,
  input  logic              sda_in
);
  logic              accept, tick, idle, sh_en, tx_msb;
  logic              fin, fin_rd, fin_wr, ack_smp;
  logic [BYTE_W-1:0] sh_q;
  logic              done_q, nack_q;
  logic [BYTE_W-1:0] data_q;
  seq_e              seq_state;

  assign cmd_ready = idle;
  assign accept    = cmd_valid && idle;

  i2c_be_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .div_in  (quarter_div),
    .tick    (tick)
  );

  i2c_be_shift #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && (op_e'(cmd_op) == OP_WRITE)),
    .load_val (cmd_data),
    .shift    (sh_en),
    .sin      (sda_in),
    .q        (sh_q),
    .msb      (tx_msb)
  );

  i2c_be_seq #(.BYTE_W(BYTE_W), .RCV_PULSES(RCV_PULSES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .op       (cmd_op),
    .nack_in  (cmd_nack),
    .tick     (tick),
    .tx_msb   (tx_msb),
    .sda_in   (sda_in),
    .idle     (idle),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .sh_en    (sh_en),
    .fin      (fin),
    .fin_rd   (fin_rd),
    .fin_wr   (fin_wr),
    .ack_smp  (ack_smp),
    .st_o     (seq_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      nack_q <= 1'b0;
      data_q <= '0;
    end else begin
      done_q <= fin;
      if (fin_rd) data_q <= sh_q;
      if (fin_wr) nack_q <= ack_smp;
    end
  end

  assign done     = done_q;
  assign rsp_data = data_q;
  assign rsp_nack = nack_q;
endmodule

// File: rtl/i2c_be_chk.sv
module i2c_be_chk
  import i2c_be_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic         done,
  input logic [W-1:0] rsp_data,
  input logic         rsp_nack,
  input logic         scl_pull,
  input logic         sda_pull,
  input seq_e         st
);
  // R2: a completion pulse always finds the engine idle
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R2 and R11: a taken command either makes the engine busy or completes at once
  assert_accept_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready || done));

  // R6: during byte and recovery clocking SDA only moves while SCL is held low
  assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((st == S_WR) || (st == S_RD) || (st == S_RCLK)) && !$stable(sda_pull)) |-> scl_pull);

  // R10: SDA is never pulled during the recovery pulses
  assert_rcv_sda_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RCLK) |-> !sda_pull);

  // R12: responses only move together with the completion pulse
  assert_rsp_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rsp_data));
  assert_rsp_nack_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rsp_nack));

  // R13: an idle engine with no command keeps both lines
  assert_idle_lines_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> ($stable(scl_pull) && $stable(sda_pull)));
endmodule

bind i2c_bit_engine i2c_be_chk #(.W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done      (done),
  .rsp_data  (rsp_data),
  .rsp_nack  (rsp_nack),
  .scl_pull  (scl_pull),
  .sda_pull  (sda_pull),
  .st        (seq_state)
);

// File: tb/tb_i2c_bit_engine.sv
module tb_i2c_bit_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] quarter_div = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_nack = 1'b0;
  logic        done;
  logic [7:0]  rsp_data;
  logic        rsp_nack;
  logic        scl_pull, sda_pull;
  logic        slv_pull = 1'b0;
  wire         sda_line = !(sda_pull || slv_pull);

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  i2c_bit_engine dut (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .done(done),
    .rsp_data(rsp_data), .rsp_nack(rsp_nack),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_line)
  );

  // Expected per-unit levels (1 = pulled low) and slave pull
  logic e_scl [0:63];
  logic e_sda [0:63];
  logic e_slv [0:63];
  int   n_units;
  logic cur_scl = 1'b0;
  logic cur_sda = 1'b0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic s, input logic d, input logic v);
    e_scl[n_units] = s;
    e_sda[n_units] = d;
    e_slv[n_units] = v;
    cur_scl = s;
    cur_sda = d;
    n_units++;
  endtask

  // R5 stop pattern
  task automatic push_stop();
    push(1'b1, cur_sda, 1'b0);
    push(1'b1, 1'b1, 1'b0);
    push(1'b0, 1'b1, 1'b0);
    push(1'b0, 1'b0, 1'b0);
  endtask

  task automatic build(input logic [2:0] op, input logic [7:0] wd, input logic nk,
                       input logic [7:0] sb, input logic sack);
    n_units = 0;
    case (op)
      3'd0: begin // R10
        push(1'b0, 1'b0, 1'b0);
        for (int p = 0; p < 9; p++) begin
          push(1'b1, 1'b0, 1'b0); push(1'b1, 1'b0, 1'b0);
          push(1'b0, 1'b0, 1'b0); push(1'b0, 1'b0, 1'b0);
        end
        push_stop();
      end
      3'd1: begin // R4
        push(cur_scl, 1'b0, 1'b0);
        push(1'b0, 1'b0, 1'b0);
        push(1'b0, 1'b1, 1'b0);
      end
      3'd2: push_stop();
      3'd3: begin // R6 and R7
        for (int b = 7; b >= 0; b--) begin
          push(1'b1, cur_sda, 1'b0);
          push(1'b1, !wd[b], 1'b0);
          push(1'b0, !wd[b], 1'b0);
          push(1'b0, !wd[b], 1'b0);
        end
        push(1'b1, cur_sda, 1'b0);
        push(1'b1, 1'b0, sack);
        push(1'b0, 1'b0, sack);
        push(1'b0, 1'b0, sack);
        push(1'b1, 1'b0, sack);
      end
      3'd4: begin // R8 and R9
        for (int b = 7; b >= 0; b--) begin
          push(1'b1, 1'b0, !sb[b]);
          push(1'b0, 1'b0, !sb[b]);
          push(1'b0, 1'b0, !sb[b]);
        end
        push(1'b1, 1'b0, 1'b0);
        push(1'b1, !nk, 1'b0);
        push(1'b0, !nk, 1'b0);
        push(1'b0, !nk, 1'b0);
        push(1'b1, !nk, 1'b0);
      end
      default: ; // R11: no units
    endcase
  endtask

  function automatic string op_tag(input logic [2:0] op, input int k);
    case (op)
      3'd0: return "R10";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return (k >= 32) ? "R7" : "R6";
      3'd4: return (k >= 24) ? "R9" : "R8";
      default: return "R11";
    endcase
  endfunction

  // Issue one command and check it unit by unit; q is captured, qalt is applied afterwards (R3)
  task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input logic nk,
                         input logic [7:0] sb, input logic sack,
                         input logic [15:0] q, input logic [15:0] qalt);
    int n;
    logic [7:0] old_d;
    logic old_n;
    n = (q == 0) ? 1 : int'(q);
    old_d = rsp_data;
    old_n = rsp_nack;
    build(op, wd, nk, sb, sack);
    quarter_div = q;
    cmd_op = op;
    cmd_data = wd;
    cmd_nack = nk;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    quarter_div = qalt;
    cmd_data = 8'($urandom);
    cmd_nack = 1'($urandom);
    for (int k = 0; k < n_units; k++) begin
      slv_pull = e_slv[k];
      chk((scl_pull == e_scl[k]) && (sda_pull == e_sda[k]) && !cmd_ready && !done,
          op_tag(op, k), $sformatf("unit %0d {scl,sda,ready,done}", k),
          {28'd0, scl_pull, sda_pull, cmd_ready, done},
          {28'd0, e_scl[k], e_sda[k], 2'b00});
      repeat (n) @(negedge clk);
    end
    slv_pull = 1'b0;
    // R2 and R3: completion due exactly units*N cycles after acceptance
    chk(done && cmd_ready, "R2", "completion {done,ready}", {30'd0, done, cmd_ready}, 32'd3);
    if (op == 3'd4) chk(rsp_data == sb, "R8", "rsp_data", rsp_data, sb);
    else            chk(rsp_data == old_d, "R12", "rsp_data held", rsp_data, old_d);
    if (op == 3'd3) chk(rsp_nack == !sack, "R7", "rsp_nack", rsp_nack, !sack);
    else            chk(rsp_nack == old_n, "R12", "rsp_nack held", rsp_nack, old_n);
    @(negedge clk);
    chk(!done, "R2", "single done pulse", done, 0);
    chk((scl_pull == cur_scl) && (sda_pull == cur_sda), "R13", "idle lines {scl,sda}",
        {30'd0, scl_pull, sda_pull}, {30'd0, cur_scl, cur_sda});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!scl_pull && !sda_pull && cmd_ready && !done, "R1", "reset {scl,sda,ready,done}",
        {28'd0, scl_pull, sda_pull, cmd_ready, done}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_pull && !sda_pull && cmd_ready && !done, "R1", "after reset",
        {28'd0, scl_pull, sda_pull, cmd_ready, done}, 32'd2);

    // Directed corner cases
    run_cmd(3'd0, 8'h00, 1'b0, 8'h00, 1'b0, 16'd0, 16'd3);  // R10 recovery, R3 divisor zero
    run_cmd(3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 16'd2, 16'd0);  // R4 start
    run_cmd(3'd3, 8'hA5, 1'b0, 8'h00, 1'b1, 16'd2, 16'd5);  // R6 write, R7 acknowledged
    run_cmd(3'd3, 8'h00, 1'b0, 8'h00, 1'b0, 16'd1, 16'd2);  // R7 no acknowledge
    run_cmd(3'd1, 8'h00, 1'b0, 8'h00, 1'b0, 16'd3, 16'd1);  // R4 repeated start from SCL low
    run_cmd(3'd4, 8'h00, 1'b0, 8'h3C, 1'b0, 16'd2, 16'd1);  // R8 read, R9 acknowledge
    run_cmd(3'd4, 8'h00, 1'b1, 8'hFF, 1'b0, 16'd1, 16'd4);  // R9 not acknowledge
    run_cmd(3'd7, 8'h12, 1'b0, 8'h00, 1'b0, 16'd3, 16'd1);  // R11 unused opcode
    run_cmd(3'd2, 8'h00, 1'b0, 8'h00, 1'b0, 16'd4, 16'd0);  // R5 stop

    // Random stream
    for (int i = 0; i < 40; i++) begin
      run_cmd(3'($urandom_range(0, 7)), 8'($urandom), 1'($urandom), 8'($urandom),
              1'($urandom), 16'($urandom_range(0, 3)), 16'($urandom_range(0, 3)));
    end
    finish_run();
  end
endmodule